// File: doc/BRIEF.md
# Time-aware transmit gate scheduler

This block drives eight per-traffic-class transmit gates from a repeating gate control list, timed against a 64-bit nanosecond time input. Software stages an administrative list through an entry write port. Each entry holds a gate mask and an interval. Software also writes a base time, a cycle time and a cycle-time extension through a small register port. It then commits the list by writing the control register with the enable bit set and an entry count. The resulting gate-open vector feeds the downstream queue arbitration.

A committed list first aligns to a cycle boundary. That boundary is the base time plus a whole number of cycle times that is not earlier than the present time. A base time of zero means "now". The list starts there and steps through its entries once per cycle. It holds the last mask until the cycle ends. A list committed while another is running takes over only at a cycle boundary of the running list. A running cycle may instead be stretched up to the extension so that no runt cycle is produced. The block exports a flag while scheduling is enabled, so that per-queue launch-time transmission can be kept off. A commit attempted while launch-time transmission is active is refused.

Top module: `tgate_sched`

## Requirements
- R1: `cap_max_len` reports the parameter MAX_LEN (default 8). A commit whose count exceeds it is refused: `cfg_rej` is high in the cycle after the write, and the scheduler state is left unchanged. A count equal to MAX_LEN is accepted.
- R2: The entry port stores entry `ent_idx` with an 8-bit mask and a 32-bit interval in nanoseconds. Mask bit i set opens the gate of traffic class i, which is `gate_open[i]`.
- R3: After reset, while disabled, and before a committed list reaches its start time, `gate_open` is 8'hFF.
- R4: If the staged base time is zero at commit, the time input sampled at the commit edge serves as the base time. The first cycle then begins one cycle time later.
- R5: Cycles begin at base + n x cycle time. If the base is in the past, the first cycle begins at the first such instant that is not earlier than the time input at alignment.
- R6: When the list enters an entry, the gates take that entry's mask. The list moves to the next entry once the entry's interval has elapsed. After the last entry, its mask is held until the cycle boundary. Then the list restarts from entry 0.
- R7: A control write with bit 0 clear disables the scheduler at once. In the next cycle `gate_open` is 8'hFF and `gate_on` is low, and any pending list is dropped.
- R8: A commit made while `lt_active` is high is refused: `cfg_busy` is high in the cycle after the write, and `gate_on` is unchanged. An accepted commit raises `gate_on`, which stays high until disable so that launch-time transmission can be refused.
- R9: A list committed while another runs becomes active only at a cycle boundary of the running list. The switch happens at the first boundary at or after the new list's aligned start, so a running cycle is never cut short.
- R10: If the new list's aligned start lies after a boundary of the running list by no more than the new list's extension, the running cycle is stretched. The last mask is held, and the new list starts exactly at its aligned start.
- R11: Register addresses on `reg_addr`: 0 is base time low word, 1 is base time high word, 2 is cycle time, 3 is cycle-time extension, and 4 is control. The control register carries the enable in bit 0 and the entry count in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now | input | 64 | Current time in nanoseconds |
| lt_active | input | 1 | High while any queue has launch-time transmission enabled |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| ent_we | input | 1 | List entry write strobe |
| ent_idx | input | 3 | List entry index |
| ent_mask | input | 8 | Gate mask of the entry |
| ent_ivl | input | 32 | Interval of the entry in nanoseconds |
| cap_max_len | output | 8 | Maximum number of list entries |
| gate_open | output | 8 | Gate-open vector, one bit per traffic class |
| gate_on | output | 1 | Scheduling enabled (list pending or running) |
| cfg_busy | output | 1 | One-cycle pulse: commit refused because of launch-time transmission |
| cfg_rej | output | 1 | One-cycle pulse: commit refused because the count is too large |

## Verification
A three-entry list whose masks do not fill the whole cycle shows whether the block steps through its entries, holds the last mask and wraps at the cycle end. Three more runs differ only in the base time: one in the future, one in the past and one of zero. Together they tell apart an aligned start, a catch-up to the next boundary and a start taken from the time input. A second list committed while one is running is placed once in the middle of a cycle and once just after a boundary within the extension. This tells a deferred switch apart from a stretched cycle. Refused commits, one with too many entries and one made while launch-time transmission is active, show that nothing changes at the gates.

// File: rtl/tgate_sched.sv
`timescale 1ns/1ps
module tgate_sched #(
  parameter int NG      = 8,
  parameter int MAX_LEN = 8,
  parameter int IVW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [63:0]   now,
  input  logic          lt_active,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  input  logic          ent_we,
  input  logic [2:0]    ent_idx,
  input  logic [NG-1:0] ent_mask,
  input  logic [IVW-1:0] ent_ivl,
  output logic [7:0]    cap_max_len,
  output logic [NG-1:0] gate_open,
  output logic          gate_on,
  output logic          cfg_busy,
  output logic          cfg_rej
);
  localparam int IXW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [63:0] a_base;
  logic [31:0] a_ct, a_cte;
  logic [NG-1:0]  a_mask [MAX_LEN];
  logic [IVW-1:0] a_ivl  [MAX_LEN];
  logic [NG-1:0]  o_mask [MAX_LEN];
  logic [IVW-1:0] o_ivl  [MAX_LEN];

  logic        p_valid, p_aligned;
  logic [63:0] p_start;
  logic [31:0] p_ct, p_cte;
  logic [7:0]  p_len;

  logic        run, started;
  logic [7:0]  o_len;
  logic [31:0] o_ct;
  logic [IXW-1:0] idx;
  logic [63:0] cur_start, ent_end, cyc_end;
  logic [NG-1:0] gate;

  wire       ctl_wr  = reg_we && reg_addr == 3'd4;
  wire [7:0] req_len = reg_wdata[15:8];
  wire       dis     = ctl_wr && !reg_wdata[0];
  wire       commit  = ctl_wr && reg_wdata[0] && !lt_active && req_len <= 8'(MAX_LEN);

  wire        p_ready  = p_valid && p_aligned;
  wire        at_bound = run && started && o_ct != 32'd0 && now >= cyc_end;
  wire        near     = (p_start <= cyc_end) || ((p_start - cyc_end) <= {32'd0, p_cte});
  wire        sw_idle  = !run && p_ready;
  wire        sw_bound = at_bound && p_ready && near;
  wire        do_sw    = (sw_idle || sw_bound) && !commit && !dis;
  wire [63:0] sw_at    = (sw_idle || p_start > cyc_end) ? p_start : cyc_end;
  wire [7:0]  idx_n    = 8'(idx) + 8'd1;
  wire [IXW-1:0] idx_nx = IXW'(idx_n);

  assign cap_max_len = 8'(MAX_LEN);
  assign gate_open   = gate;
  assign gate_on     = run | p_valid;

  always_ff @(posedge clk) begin
    if (reg_we && reg_addr == 3'd0) a_base[31:0]  <= reg_wdata;
    if (reg_we && reg_addr == 3'd1) a_base[63:32] <= reg_wdata;
    if (reg_we && reg_addr == 3'd2) a_ct  <= reg_wdata;
    if (reg_we && reg_addr == 3'd3) a_cte <= reg_wdata;
    if (ent_we) begin
      a_mask[IXW'(ent_idx)] <= ent_mask;
      a_ivl[IXW'(ent_idx)]  <= ent_ivl;
    end
    if (do_sw)
      for (int i = 0; i < MAX_LEN; i++) begin
        o_mask[i] <= a_mask[i];
        o_ivl[i]  <= a_ivl[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_busy  <= 1'b0;
      cfg_rej   <= 1'b0;
      p_valid   <= 1'b0;
      p_aligned <= 1'b0;
      p_start   <= '0;
      p_ct      <= '0;
      p_cte     <= '0;
      p_len     <= '0;
      run       <= 1'b0;
      started   <= 1'b0;
      o_len     <= '0;
      o_ct      <= '0;
      idx       <= '0;
      cur_start <= '0;
      ent_end   <= '0;
      cyc_end   <= '0;
      gate      <= '1;
    end else begin
      cfg_busy <= ctl_wr && reg_wdata[0] && lt_active;
      cfg_rej  <= ctl_wr && reg_wdata[0] && !lt_active && req_len > 8'(MAX_LEN);
      if (dis) begin
        run     <= 1'b0;
        started <= 1'b0;
        p_valid <= 1'b0;
        gate    <= '1;
      end else begin
        if (commit) begin
          p_valid   <= 1'b1;
          p_aligned <= 1'b0;
          p_start   <= (a_base == 64'd0) ? now : a_base;
          p_ct      <= a_ct;
          p_cte     <= a_cte;
          p_len     <= req_len;
        end else if (p_valid && !p_aligned) begin
          if (p_ct != 32'd0 && p_start < now) p_start <= p_start + {32'd0, p_ct};
          else p_aligned <= 1'b1;
        end

        if (do_sw) begin
          p_valid   <= 1'b0;
          run       <= 1'b1;
          started   <= 1'b0;
          cur_start <= sw_at;
          o_len     <= p_len;
          o_ct      <= p_ct;
        end else if (at_bound) begin
          cur_start <= cyc_end;
          started   <= 1'b0;
        end else if (run && !started && now >= cur_start) begin
          started <= 1'b1;
          idx     <= '0;
          cyc_end <= cur_start + {32'd0, o_ct};
          ent_end <= cur_start + 64'(o_ivl[0]);
          gate    <= (o_len != 8'd0) ? o_mask[0] : '1;
        end else if (run && started && idx_n < o_len && now >= ent_end) begin
          idx     <= idx_nx;
          gate    <= o_mask[idx_nx];
          ent_end <= ent_end + 64'(o_ivl[idx_nx]);
        end
      end
    end
  end
endmodule

// File: rtl/tgate_sched_chk.sv
`timescale 1ns/1ps
module tgate_sched_chk #(
  parameter int NG      = 8,
  parameter int MAX_LEN = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lt_active,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [NG-1:0] gate_open,
  input logic          gate_on,
  input logic          cfg_busy,
  input logic          cfg_rej
);
  wire en_wr  = reg_we && reg_addr == 3'd4 && reg_wdata[0];
  wire dis_wr = reg_we && reg_addr == 3'd4 && !reg_wdata[0];
  wire too_long = reg_wdata[15:8] > 8'(MAX_LEN);

  p_len_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr && !lt_active && too_long |=> cfg_rej && $stable(gate_on));

  p_open_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |-> gate_open == '1);

  p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> !gate_on && gate_open == '1);

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr && lt_active |=> cfg_busy && !cfg_rej && $stable(gate_on));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr && !lt_active && !too_long |=> gate_on && !cfg_busy && !cfg_rej);
endmodule

bind tgate_sched tgate_sched_chk #(.NG(NG), .MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .lt_active(lt_active), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .gate_open(gate_open),
  .gate_on(gate_on), .cfg_busy(cfg_busy), .cfg_rej(cfg_rej)
);

// File: tb/tgate_sched_test.sv
`timescale 1ns/1ps
module tgate_sched_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] now = 64'd1000;
  logic lt_active = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic ent_we = 1'b0;
  logic [2:0] ent_idx = '0;
  logic [7:0] ent_mask = '0;
  logic [31:0] ent_ivl = '0;
  logic [7:0] cap_max_len, gate_open;
  logic gate_on, cfg_busy, cfg_rej;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] tc;

  tgate_sched uut (.*);

  always #2.5 clk = ~clk;
  initial forever @(posedge clk) now <= now + 64'd5;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at now=%0d", req, act, exp, now);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; tc = now;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic went(input int i, input logic [7:0] m, input logic [31:0] iv);
    @(negedge clk);
    ent_we = 1'b1; ent_idx = 3'(i); ent_mask = m; ent_ivl = iv;
    @(negedge clk);
    ent_we = 1'b0;
  endtask

  task automatic setup(input logic [63:0] b, input logic [31:0] ct, input logic [31:0] cte);
    wr(3'd0, b[31:0]);
    wr(3'd1, b[63:32]);
    wr(3'd2, ct);
    wr(3'd3, cte);
  endtask

  task automatic commit(input int len);
    wr(3'd4, (32'(len) << 8) | 32'd1);
  endtask

  task automatic disable_s();
    wr(3'd4, 32'd0);
  endtask

  task automatic wait_t(input logic [63:0] t);
    while (now < t) @(negedge clk);
  endtask

  function automatic logic [63:0] next_k(input logic [63:0] t);
    return ((t + 64'd500) / 64'd1000 + 64'd1) * 64'd1000;
  endfunction

  task automatic t_reset();
    chk("R3 reset gates open", gate_open, 8'hFF);
    chk("R8 reset gate_on low", gate_on, 0);
    chk("R1 capability", cap_max_len, 8'd8);
  endtask

  task automatic t_basic();
    logic [63:0] b;
    went(0, 8'h01, 200);
    went(1, 8'h02, 300);
    went(2, 8'h04, 100);
    b = next_k(now);
    setup(b, 1000, 0);
    commit(3);
    chk("R8 gate_on after commit", gate_on, 1);
    wait_t(b - 200); chk("R3 open before start", gate_open, 8'hFF);
    wait_t(b + 100); chk("R6 R11 entry0", gate_open, 8'h01);
    wait_t(b + 350); chk("R6 entry1", gate_open, 8'h02);
    wait_t(b + 550); chk("R6 entry2", gate_open, 8'h04);
    wait_t(b + 800); chk("R6 last held", gate_open, 8'h04);
    wait_t(b + 1100); chk("R5 second cycle entry0", gate_open, 8'h01);
    wait_t(b + 1400); chk("R5 second cycle entry1", gate_open, 8'h02);
  endtask

  task automatic t_disable();
    disable_s();
    chk("R7 gates open after disable", gate_open, 8'hFF);
    chk("R7 gate_on low", gate_on, 0);
  endtask

  task automatic t_length();
    logic [63:0] b;
    commit(9);
    chk("R1 reject pulse", cfg_rej, 1);
    chk("R1 reject no enable", gate_on, 0);
    chk("R1 reject gates open", gate_open, 8'hFF);
    for (int i = 0; i < 8; i++) went(i, 8'(1 << i), 100);
    b = next_k(now);
    setup(b, 800, 0);
    commit(8);
    chk("R1 max count no reject", cfg_rej, 0);
    chk("R1 max count accepted", gate_on, 1);
    wait_t(b + 150); chk("R2 class1 bit", gate_open, 8'h02);
    wait_t(b + 750); chk("R1 R2 last of eight", gate_open, 8'h80);
    disable_s();
  endtask

  task automatic t_busy();
    lt_active = 1'b1;
    commit(1);
    chk("R8 busy pulse", cfg_busy, 1);
    chk("R8 refused no enable", gate_on, 0);
    chk("R8 refused gates open", gate_open, 8'hFF);
    lt_active = 1'b0;
  endtask

  task automatic t_past();
    logic [63:0] b;
    went(0, 8'h10, 500);
    went(1, 8'h20, 500);
    setup(64'd100, 1000, 0);
    while (now % 1000 != 300) @(negedge clk);
    commit(2);
    b = tc + 800;
    wait_t(b - 300); chk("R5 past base waits", gate_open, 8'hFF);
    wait_t(b + 250); chk("R5 aligned entry0", gate_open, 8'h10);
    wait_t(b + 750); chk("R5 aligned entry1", gate_open, 8'h20);
    disable_s();
  endtask

  task automatic t_zero();
    logic [63:0] b;
    went(0, 8'h33, 400);
    setup(64'd0, 400, 0);
    commit(1);
    b = tc + 400;
    wait_t(b - 200); chk("R4 not yet started", gate_open, 8'hFF);
    wait_t(b + 200); chk("R4 started from time input", gate_open, 8'h33);
    disable_s();
  endtask

  task automatic run_a(output logic [63:0] b);
    went(0, 8'h01, 500);
    went(1, 8'h02, 500);
    b = next_k(now);
    setup(b, 1000, 0);
    commit(2);
  endtask

  task automatic t_boundary();
    logic [63:0] b;
    run_a(b);
    wait_t(b + 100);
    went(0, 8'h80, 1000);
    setup(b + 1500, 1000, 0);
    commit(1);
    wait_t(b + 1100); chk("R9 old list keeps running", gate_open, 8'h01);
    wait_t(b + 1700); chk("R9 not cut mid-cycle", gate_open, 8'h02);
    wait_t(b + 2200); chk("R9 switch at boundary", gate_open, 8'h80);
    disable_s();
  endtask

  task automatic t_extend();
    logic [63:0] b;
    run_a(b);
    wait_t(b + 100);
    went(0, 8'h80, 1000);
    setup(b + 1100, 1000, 200);
    commit(1);
    wait_t(b + 700); chk("R10 before stretch", gate_open, 8'h02);
    wait_t(b + 1050); chk("R10 cycle stretched", gate_open, 8'h02);
    wait_t(b + 1300); chk("R10 new list at its start", gate_open, 8'h80);
    wait_t(b + 2150); chk("R10 new list repeats", gate_open, 8'h80);
    disable_s();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_disable();
    t_length();
    t_busy();
    t_past();
    t_zero();
    t_boundary();
    t_extend();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule